// File: doc/BRIEF.md
# JTAG test clock generator with return-clock follow

This block produces the JTAG test clock from a 64 MHz reference. It runs in one of two modes. In divider mode, TCK is the reference divided by an even ratio that software programs. In return-clock mode, each TCK edge is launched only after the target echoes the previous edge back on its returned clock. The returned clock is first brought into the reference domain by a synchronizer.

The host controls the block through a divisor write port and a pair of control write strobes. One strobe sets control bits and the other clears them. If the returned clock stops answering in return-clock mode, a sticky timeout flag is raised, and it stays up until software clears it. The shift engine downstream uses `tick_o` to advance on each rising TCK edge. Software changes the divisor and the mode only while that engine is idle.

Top module: `jtag_tck_gen`

## Requirements
- R1: After reset: `tck_o` = 0, `tick_o` = 0, `timeout_o` = 0, divider mode (`rclk_mode_o` = 0), `div_o` = 8190. The first rising edge of TCK comes DIV_RESET/2 cycles after reset is released.
- R2: On a divisor write, bit 0 of `div_wdata_i` is discarded (stored as 0). A value below 2 after this masking is stored as 2. `div_o` shows the stored divisor from the cycle after the write.
- R3: In divider mode, TCK has a period of `div_o` reference cycles, with `div_o`/2 cycles high and `div_o`/2 cycles low.
- R4: `tick_o` is a single-cycle pulse. It is high exactly in the first cycle in which `tck_o` is high after being low.
- R5: A write to the set strobe with bit 8 of `ctrl_wdata_i` set selects return-clock mode. A write to the clear strobe with bit 8 set selects divider mode. If both strobes carry bit 8 in the same cycle, the clear wins.
- R6: In return-clock mode, TCK toggles only in the cycle after the synchronized returned clock equals `tck_o`. With `rclk_i` looped straight back, each TCK phase lasts SYNC_STAGES+1 cycles. With `rclk_i` held, TCK holds.
- R7: In return-clock mode, `timeout_o` sets after TIMEOUT_CYC consecutive cycles in which the synchronized returned clock differs from `tck_o`. Once set, it stays set even if the returned clock resumes.
- R8: A write to the clear strobe with bit 10 set clears `timeout_o` and restarts the wait count. Bit 10 on the set strobe has no effect.
- R9: In divider mode, `rclk_i` has no effect on TCK and `timeout_o` never sets.
- R10: A divisor write or a mode change restarts the phase count without changing the `tck_o` level. The next toggle comes `div_o`/2 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 64 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | DIV_W | Divisor write data |
| set_we_i | input | 1 | Control set strobe (each 1 bit in data sets that control bit) |
| clr_we_i | input | 1 | Control clear strobe (each 1 bit in data clears that control bit) |
| ctrl_wdata_i | input | CTRL_W | Control write data: bit 8 = return-clock mode, bit 10 = timeout |
| rclk_i | input | 1 | Returned clock from target, asynchronous |
| tck_o | output | 1 | JTAG test clock |
| tick_o | output | 1 | One-cycle pulse on each TCK rising edge |
| rclk_mode_o | output | 1 | 1 = return-clock mode, 0 = divider mode |
| div_o | output | DIV_W | Stored divisor |
| timeout_o | output | 1 | Sticky return-clock timeout flag |

## Verification
The hardest state to reach is a stalled return-clock handshake that has lasted long enough to time out. From there, the bench must show that the flag survives both a resumed returned clock and a bit-10 write on the set strobe. The bench drives `rclk_i` from a selectable source: a zero-delay loopback of `tck_o`, or a held level. It switches between the two mid-run, so the block moves from a live handshake into a stall. The timeout window is shortened through a parameter, so the stall crosses the threshold within a few hundred cycles. A mid-phase divisor rewrite, timed just after a rising edge, exposes the phase restart.

// File: rtl/jtag_tck_pkg.sv
package jtag_tck_pkg;
  localparam int unsigned CTRL_MODE_BIT = 8;
  localparam int unsigned CTRL_TO_BIT   = 10;

  typedef enum logic {
    MODE_DIV  = 1'b0,
    MODE_RCLK = 1'b1
  } tck_mode_e;
endpackage

// File: rtl/jtag_tck_sync.sv
module jtag_tck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[s] <= 1'b0;
        else if (s == 0) ff_q[s] <= d_i;
        else ff_q[s] <= ff_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/jtag_tck_divider.sv
module jtag_tck_divider #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             toggle_o
);
  localparam int unsigned CNT_W = DIV_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic             hit;

  assign half     = div_i[DIV_W-1:1];
  assign hit      = (cnt_q == half - CNT_W'(1));
  assign toggle_o = en_i && !restart_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart_i || !en_i || hit) cnt_q <= '0;
    else cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/jtag_tck_rclk_follow.sv
module jtag_tck_rclk_follow #(
  parameter int unsigned TIMEOUT_CYC = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rclk_sync_i,
  input  logic tck_i,
  input  logic to_clr_i,
  output logic toggle_o,
  output logic timeout_o
);
  localparam int unsigned TO_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);

  logic            waiting;
  logic [TO_W-1:0] wait_q;
  logic            to_q;

  assign waiting  = en_i && (rclk_sync_i != tck_i);
  assign toggle_o = en_i && (rclk_sync_i == tck_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      to_q   <= 1'b0;
    end else if (to_clr_i) begin
      wait_q <= '0;
      to_q   <= 1'b0;
    end else if (waiting) begin
      if (wait_q == TO_LAST) to_q <= 1'b1;
      else wait_q <= wait_q + TO_W'(1);
    end else begin
      wait_q <= '0;
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen
  import jtag_tck_pkg::*;
#(
  parameter int unsigned DIV_W       = 13,
  parameter int unsigned CTRL_W      = 16,
  parameter int unsigned DIV_RESET   = 8190,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              rclk_i,
  output logic              tck_o,
  output logic              tick_o,
  output logic              rclk_mode_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              timeout_o
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  tck_mode_e        mode_q, mode_d;
  logic [DIV_W-1:0] div_q, div_masked;
  logic             tck_q, tick_q;
  logic             rclk_sync;
  logic             div_toggle, rclk_toggle, toggle;
  logic             restart, to_clr;

  // control set/clear; clear wins
  always_comb begin
    mode_d = mode_q;
    if (set_we_i && ctrl_wdata_i[CTRL_MODE_BIT]) mode_d = MODE_RCLK;
    if (clr_we_i && ctrl_wdata_i[CTRL_MODE_BIT]) mode_d = MODE_DIV;
  end

  assign to_clr     = clr_we_i && ctrl_wdata_i[CTRL_TO_BIT];
  assign div_masked = {div_wdata_i[DIV_W-1:1], 1'b0};
  assign restart    = div_we_i || (mode_d != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DIV;
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      mode_q <= mode_d;
      if (div_we_i) div_q <= (div_masked < DIV_MIN) ? DIV_MIN : div_masked;
    end
  end

  jtag_tck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rclk_i),
    .q_o    (rclk_sync)
  );

  jtag_tck_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_q == MODE_DIV),
    .restart_i (restart),
    .div_i     (div_q),
    .toggle_o  (div_toggle)
  );

  jtag_tck_rclk_follow #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mode_q == MODE_RCLK),
    .rclk_sync_i (rclk_sync),
    .tck_i       (tck_q),
    .to_clr_i    (to_clr),
    .toggle_o    (rclk_toggle),
    .timeout_o   (timeout_o)
  );

  assign toggle = div_toggle || rclk_toggle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tck_q  <= tck_q ^ toggle;
      tick_q <= toggle && !tck_q;
    end
  end

  assign tck_o       = tck_q;
  assign tick_o      = tick_q;
  assign rclk_mode_o = (mode_q == MODE_RCLK);
  assign div_o       = div_q;
endmodule

// File: rtl/jtag_tck_gen_chk.sv
module jtag_tck_gen_chk #(
  parameter int unsigned DIV_W  = 13,
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_we_i,
  input logic              clr_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              rclk_sync,
  input logic              tck_o,
  input logic              tick_o,
  input logic              rclk_mode_o,
  input logic [DIV_W-1:0]  div_o,
  input logic              timeout_o
);
  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert_div_even_R2: assert (!div_o[0] && div_o >= DIV_W'(2))
        else $error("divisor not even or below 2");
    end
  end

  assert_tick_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (tck_o && !$past(tck_o)));

  assert_rise_has_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && !$past(tck_o)) |-> tick_o);

  assert_hold_until_echo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rclk_mode_o && (rclk_sync != tck_o)) |=> $stable(tck_o));

  assert_timeout_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(clr_we_i && ctrl_wdata_i[10])) |=> timeout_o);

  assert_no_timeout_div_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rclk_mode_o && !timeout_o) |=> !timeout_o);

  assert_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && ctrl_wdata_i[8]) |=> !rclk_mode_o);
endmodule

bind jtag_tck_gen jtag_tck_gen_chk #(.DIV_W(DIV_W), .CTRL_W(CTRL_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .set_we_i     (set_we_i),
  .clr_we_i     (clr_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .rclk_sync    (rclk_sync),
  .tck_o        (tck_o),
  .tick_o       (tick_o),
  .rclk_mode_o  (rclk_mode_o),
  .div_o        (div_o),
  .timeout_o    (timeout_o)
);

// File: tb/jtag_tck_gen_tb_top.sv
`timescale 1ns/1ps
module jtag_tck_gen_tb_top;
  localparam int DIV_W = 13;
  localparam int CTRL_W = 16;
  localparam int TO_CYC = 100;
  localparam int NVEC = 8;
  localparam logic [DIV_W-1:0] VEC_IN  [NVEC] = '{13'd2, 13'd3, 13'd10, 13'd11, 13'd0, 13'd1, 13'd7, 13'd40};
  localparam logic [DIV_W-1:0] VEC_EXP [NVEC] = '{13'd2, 13'd2, 13'd10, 13'd10, 13'd2, 13'd2, 13'd6, 13'd40};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic div_we = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic set_we = 1'b0, clr_we = 1'b0;
  logic [CTRL_W-1:0] ctrl_wdata = '0;
  logic loop_en = 1'b0, rclk_hold = 1'b0;
  logic rclk, tck, tick, rmode, tmo;
  logic [DIV_W-1:0] div_rd;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign rclk = loop_en ? tck : rclk_hold;

  jtag_tck_gen #(.TIMEOUT_CYC(TO_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .div_we_i(div_we), .div_wdata_i(div_wdata),
    .set_we_i(set_we), .clr_we_i(clr_we), .ctrl_wdata_i(ctrl_wdata),
    .rclk_i(rclk), .tck_o(tck), .tick_o(tick), .rclk_mode_o(rmode),
    .div_o(div_rd), .timeout_o(tmo));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [DIV_W-1:0] v);
    div_wdata = v; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic wr_ctrl(input bit s, input bit c, input logic [CTRL_W-1:0] v);
    ctrl_wdata = v; set_we = s; clr_we = c;
    @(negedge clk); set_we = 1'b0; clr_we = 1'b0; ctrl_wdata = '0;
  endtask

  // wait for a rise, then count high and low phases; ticks counted over the period
  task automatic measure(output int hi, output int lo, output int ticks);
    int g;
    hi = 0; lo = 0; ticks = 0; g = 0;
    while (tck && g < 20000) begin @(negedge clk); g++; end
    while (!tck && g < 20000) begin @(negedge clk); g++; end
    while (tck && g < 20000) begin if (tick) ticks++; hi++; @(negedge clk); g++; end
    while (!tck && g < 20000) begin if (tick) ticks++; lo++; @(negedge clk); g++; end
  endtask

  initial begin
    int hi, lo, tk, n;
    logic ref_tck;
    bit moved;
    @(negedge clk); @(negedge clk);
    check("R1 tck", tck, 0); check("R1 tick", tick, 0); check("R1 timeout", tmo, 0);
    check("R1 mode", rmode, 0); check("R1 div", div_rd, 8190);
    rst_ni = 1'b1;
    n = 0;
    while (!tck && n < 5000) begin @(negedge clk); n++; end
    check("R1 first rise", n, 4095);

    // vector table walk: divisor masking and divided period
    for (int i = 0; i < NVEC; i++) begin
      wr_div(VEC_IN[i]);
      check("R2 stored divisor", div_rd, VEC_EXP[i]);
      measure(hi, lo, tk); measure(hi, lo, tk);
      check("R3 high cycles", hi, VEC_EXP[i] / 2);
      check("R3 low cycles", lo, VEC_EXP[i] / 2);
      check("R4 ticks per period", tk, 1);
    end

    // R10: rewrite divisor mid-high-phase
    wr_div(13'd40);
    measure(hi, lo, tk);
    while (!tck) @(negedge clk);
    repeat (3) @(negedge clk);
    wr_div(13'd10);
    n = 0;
    while (tck && n < 100) begin @(negedge clk); n++; end
    check("R10 phase restart", n, 5);

    // R9: rclk has no effect in divider mode
    loop_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      rclk_hold = k[0];
      measure(hi, lo, tk);
      check("R9 high with rclk moving", hi, 5);
    end
    check("R9 no timeout in divider mode", tmo, 0);

    // R5: clear wins over set
    wr_ctrl(1'b1, 1'b1, 16'h0100);
    check("R5 clear wins", rmode, 0);
    wr_ctrl(1'b1, 1'b0, 16'h0100);
    check("R5 set selects rclk", rmode, 1);

    // R6: loopback follow
    loop_en = 1'b1;
    measure(hi, lo, tk); measure(hi, lo, tk);
    check("R6 high phase", hi, 3); check("R6 low phase", lo, 3);
    check("R4 ticks in rclk mode", tk, 1);

    // R6: stall holds tck; R7 not yet timed out
    loop_en = 1'b0; rclk_hold = 1'b0;
    repeat (10) @(negedge clk);
    ref_tck = tck; moved = 1'b0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (tck != ref_tck) moved = 1'b1; end
    check("R6 tck held while stalled", moved, 0);
    check("R7 timeout not early", tmo, 0);
    repeat (TO_CYC) @(negedge clk);
    check("R7 timeout set", tmo, 1);
    wr_ctrl(1'b1, 1'b0, 16'h0400);
    check("R8 set of bit 10 ignored", tmo, 1);
    loop_en = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 sticky after echo resumes", tmo, 1);
    wr_ctrl(1'b0, 1'b1, 16'h0400);
    check("R8 clear", tmo, 0);
    loop_en = 1'b0; rclk_hold = ~tck;
    repeat (TO_CYC / 2) @(negedge clk);
    check("R8 wait count restarted", tmo, 0);
    loop_en = 1'b1;

    // back to divider mode, rclk stuck
    wr_ctrl(1'b0, 1'b1, 16'h0100);
    check("R5 clear selects divider", rmode, 0);
    loop_en = 1'b0; rclk_hold = 1'b1;
    repeat (3 * TO_CYC) @(negedge clk);
    check("R9 no timeout with rclk stuck", tmo, 0);
    measure(hi, lo, tk);
    check("R9 divider runs", hi, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..all) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule